// File: doc/BRIEF.md
# Walking-Ones Link Test Generator

This block sits on the source side of a parallel data link and runs its diagnostic mode. While it is idle it stays out of the way: the data bus is zero, the active-low control flag is high and the link is reported as up. When the active-low test request is seen low, the block takes over the link. It reports the link as down to the upstream producer so that no user data is offered, and it sends a repeating calibration sequence. Each sequence starts with an all-zero word that carries the control flag low. Then a single set bit walks from the least significant position to the most significant one, with the control flag high.

The width of the data bus is a parameter (8, 16 or 32 bits in practice), so one sequence is width+1 words long. A request held low repeats the sequence without a break. A request that returns high only ends test mode at the end of the sequence in progress, so a short request yields exactly one full sequence. When the test words are also forwarded to the downstream receiver, an active-low pause input from that receiver freezes the sequence on its current word. Each change into or out of test mode emits a one-cycle pulse that clears error latches and flushes pending buffers on the normal data path.

Top module: `lwt_gen`

## Requirements
- R1: The first word of every sequence, including the first word after entry into test mode, is all zeros with `link_ctrl_n` low.
- R2: Every other word in test mode has exactly one bit set and `link_ctrl_n` high. The word after the zero word is 1 (bit 0), and each later word is the previous one shifted left by one position.
- R3: With the request held low and no pause, zero words recur every W+1 cycles, so the sequence repeats from the zero word after the word with bit W-1 set.
- R4: `link_down_n` goes low and `test_active` goes high on the third rising edge at which `test_req_n` has been sampled low. They stay in that state throughout test mode, and `link_down_n` always equals the inverse of `test_active`.
- R5: Test mode ends only on the edge after the word with bit W-1 set has been sent. A request low for 4 sampled edges yields exactly W+1 valid words and then a return to idle.
- R6: With forwarding enabled (`fwd_en_n` low), a cycle in which `pause_n` is sampled low keeps `link_data` unchanged on the next cycle and drives `data_valid` low. Test mode cannot end while paused.
- R7: With forwarding disabled (`fwd_en_n` high), `pause_n` has no effect: the word advances and `data_valid` stays high on every test-mode cycle.
- R8: `clr_pulse` is high for exactly one cycle on the cycle that `test_active` rises and on the cycle it falls, and at no other time.
- R9: Out of reset and while idle, `link_data` is 0, `link_ctrl_n` is 1, `data_valid` is 0, `link_down_n` is 1, `test_active` is 0 and `clr_pulse` is 0.
- R10: `data_valid` is high on each test-mode cycle in which a new word is presented (entry, advance or wrap), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_req_n | input | 1 | Active-low test request, asynchronous, synchronized internally |
| fwd_en_n | input | 1 | Active-low enable for forwarding test words downstream (makes pause effective) |
| pause_n | input | 1 | Active-low downstream pause |
| link_data | output | W | Link data bus |
| link_ctrl_n | output | 1 | Active-low control flag, low on the zero word |
| data_valid | output | 1 | High when a new test word is presented |
| link_down_n | output | 1 | Active-low link-down status to the upstream producer |
| test_active | output | 1 | Registered test-mode indicator |
| clr_pulse | output | 1 | One-cycle clear for error latches and pending buffers |

## Verification
The bench builds the block with W = 8, so each sequence lasts only nine cycles. Several full wraps, a single-pulse sequence, an exit deferred to the end of a sequence and pauses at arbitrary words all fit in a few hundred cycles. At this width the walking bit still crosses every bus position, and the period check compares directly against W+1. The default of 32 bits is exercised only through elaboration and the width-generic assertions.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    typedef enum logic {
        MODE_XFER = 1'b0,
        MODE_TEST = 1'b1
    } lwt_mode_e;

endpackage

// File: rtl/lwt_sync.sv
module lwt_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d};
        end
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/lwt_seq.sv
module lwt_seq
    import lwt_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         fwd_en,
    input  logic         pause,
    output logic [W-1:0] data,
    output logic         ctrl_n,
    output logic         valid,
    output logic         down_n,
    output logic         active,
    output logic         clr
);

    localparam logic [IW-1:0] LAST_IDX = IW'(W);

    typedef struct packed {
        lwt_mode_e      mode;
        logic [IW-1:0]  idx;
        logic [W-1:0]   data;
        logic           ctrl_n;
        logic           valid;
        logic           down_n;
        logic           clr;
    } seq_st_t;

    seq_st_t cur_q;
    seq_st_t nxt_d;
    logic    stall;
    logic    at_last;

    // word for a sequence index: index 0 is the zero word, index k sets bit k-1
    function automatic logic [W-1:0] walk_word(input logic [IW-1:0] i);
        logic [W-1:0] w;
        w = '0;
        for (int b = 0; b < W; b++) begin
            if (i == IW'(b + 1)) begin
                w[b] = 1'b1;
            end
        end
        return w;
    endfunction

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        nxt_d.clr   = 1'b0;
        stall       = (cur_q.mode == MODE_TEST) && fwd_en && pause;
        at_last     = (cur_q.idx == LAST_IDX);

        unique case (cur_q.mode)
            MODE_XFER: begin
                if (req) begin
                    nxt_d.mode  = MODE_TEST;
                    nxt_d.idx   = '0;
                    nxt_d.valid = 1'b1;
                    nxt_d.clr   = 1'b1;
                end
            end
            MODE_TEST: begin
                if (!stall) begin
                    if (!at_last) begin
                        nxt_d.idx   = cur_q.idx + 1'b1;
                        nxt_d.valid = 1'b1;
                    end else if (req) begin
                        nxt_d.idx   = '0;
                        nxt_d.valid = 1'b1;
                    end else begin
                        nxt_d.mode = MODE_XFER;
                        nxt_d.idx  = '0;
                        nxt_d.clr  = 1'b1;
                    end
                end
            end
            default: begin
                nxt_d.mode = MODE_XFER;
            end
        endcase

        if (nxt_d.mode == MODE_TEST) begin
            nxt_d.data   = walk_word(nxt_d.idx);
            nxt_d.ctrl_n = (nxt_d.idx != '0);
            nxt_d.down_n = 1'b0;
        end else begin
            nxt_d.data   = '0;
            nxt_d.ctrl_n = 1'b1;
            nxt_d.down_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.mode   <= MODE_XFER;
            cur_q.idx    <= '0;
            cur_q.data   <= '0;
            cur_q.ctrl_n <= 1'b1;
            cur_q.valid  <= 1'b0;
            cur_q.down_n <= 1'b1;
            cur_q.clr    <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign data   = cur_q.data;
    assign ctrl_n = cur_q.ctrl_n;
    assign valid  = cur_q.valid;
    assign down_n = cur_q.down_n;
    assign active = (cur_q.mode == MODE_TEST);
    assign clr    = cur_q.clr;

endmodule

// File: rtl/lwt_gen.sv
module lwt_gen #(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_req_n,
    input  logic         fwd_en_n,
    input  logic         pause_n,
    output logic [W-1:0] link_data,
    output logic         link_ctrl_n,
    output logic         data_valid,
    output logic         link_down_n,
    output logic         test_active,
    output logic         clr_pulse
);

    localparam int IW = $clog2(W + 1);

    logic req_s;

    lwt_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~test_req_n),
        .q     (req_s)
    );

    lwt_seq #(
        .W  (W),
        .IW (IW)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_s),
        .fwd_en (~fwd_en_n),
        .pause  (~pause_n),
        .data   (link_data),
        .ctrl_n (link_ctrl_n),
        .valid  (data_valid),
        .down_n (link_down_n),
        .active (test_active),
        .clr    (clr_pulse)
    );

endmodule

// File: rtl/lwt_gen_chk.sv
module lwt_gen_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         test_req_n,
    input logic         fwd_en_n,
    input logic         pause_n,
    input logic [W-1:0] link_data,
    input logic         link_ctrl_n,
    input logic         data_valid,
    input logic         link_down_n,
    input logic         test_active,
    input logic         clr_pulse
);

    logic [2:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!test_req_n) begin
            if (low_cnt_q != 3'd7) begin
                low_cnt_q <= low_cnt_q + 3'd1;
            end
        end else begin
            low_cnt_q <= '0;
        end
    end

    p_zero_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && !link_ctrl_n) |-> (link_data == '0));

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && link_ctrl_n) |-> ($countones(link_data) == 1));

    p_first_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && data_valid && $past(test_active) && !$past(link_ctrl_n))
        |-> (link_data == W'(1) && link_ctrl_n));

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && link_ctrl_n && $past(test_active) && $past(link_ctrl_n))
        |-> ((link_data == ($past(link_data) << 1)) || (link_data == $past(link_data))));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt_q >= 3'd4) |-> (!link_down_n && test_active));

    p_down_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_down_n == !test_active);

    p_exit_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_active) |-> ($past(link_data[W-1]) && $past(link_ctrl_n)));

    p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && !fwd_en_n && !pause_n)
        |=> ($stable(link_data) && !data_valid && test_active));

    p_pause_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active && fwd_en_n) |=> (data_valid || !test_active));

    p_clr_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> (test_active != $past(test_active)));

    p_clr_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_active != $past(test_active)) |-> clr_pulse);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_active |-> (link_data == '0 && link_ctrl_n && !data_valid));

endmodule

bind lwt_gen lwt_gen_chk #(.W(W)) u_lwt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_req_n  (test_req_n),
    .fwd_en_n    (fwd_en_n),
    .pause_n     (pause_n),
    .link_data   (link_data),
    .link_ctrl_n (link_ctrl_n),
    .data_valid  (data_valid),
    .link_down_n (link_down_n),
    .test_active (test_active),
    .clr_pulse   (clr_pulse)
);

// File: tb/lwt_gen_test.sv
`timescale 1ns/1ps
module lwt_gen_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_req_n = 1'b1;
    logic         fwd_en_n = 1'b1;
    logic         pause_n = 1'b1;
    logic [W-1:0] link_data;
    logic         link_ctrl_n;
    logic         data_valid;
    logic         link_down_n;
    logic         test_active;
    logic         clr_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    bit ready = 1'b0;

    always #2.5 clk = ~clk;

    lwt_gen #(.W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_req_n  (test_req_n),
        .fwd_en_n    (fwd_en_n),
        .pause_n     (pause_n),
        .link_data   (link_data),
        .link_ctrl_n (link_ctrl_n),
        .data_valid  (data_valid),
        .link_down_n (link_down_n),
        .test_active (test_active),
        .clr_pulse   (clr_pulse)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: request pipeline as a small queue, mode as integers
    bit m_act, m_valid, m_clr;
    int m_idx;
    bit req_pipe[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_valid = 0; m_clr = 0; m_idx = 0;
            req_pipe = '{0, 0};
        end else begin
            bit seen;
            bit hold;
            seen = req_pipe.pop_front();
            req_pipe.push_back(!test_req_n);
            hold = m_act && !fwd_en_n && !pause_n;
            m_clr = 0;
            if (!m_act) begin
                m_valid = 0;
                if (seen) begin m_act = 1; m_idx = 0; m_valid = 1; m_clr = 1; end
            end else if (hold) begin
                m_valid = 0;
            end else if (m_idx < W) begin
                m_idx++; m_valid = 1;
            end else if (seen) begin
                m_idx = 0; m_valid = 1;
            end else begin
                m_act = 0; m_idx = 0; m_valid = 0; m_clr = 1;
            end
        end
    end

    function automatic int exp_word();
        if (!m_act || m_idx == 0) return 0;
        return 1 << (m_idx - 1);
    endfunction

    always @(negedge clk) begin
        if (ready && !done) begin
            check(int'(link_data) == exp_word(), "R2", "link_data", link_data, exp_word());
            check(link_ctrl_n == !(m_act && m_idx == 0), "R1", "link_ctrl_n",
                  link_ctrl_n, !(m_act && m_idx == 0));
            check(data_valid == m_valid, "R10", "data_valid", data_valid, m_valid);
            check(link_down_n == !m_act, "R4", "link_down_n", link_down_n, !m_act);
            check(test_active == m_act, "R4", "test_active", test_active, m_act);
            check(clr_pulse == m_clr, "R8", "clr_pulse", clr_pulse, m_clr);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all): actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lat, words, clrs, t;
        int zpos[$];
        logic [W-1:0] held, prev, last_w;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle state after reset
        check(link_data == '0 && link_ctrl_n && !data_valid, "R9", "idle bus", link_data, 0);
        check(link_down_n && !test_active && !clr_pulse, "R9", "idle status",
              {link_down_n, test_active, clr_pulse}, 4);
        ready = 1'b1;
        repeat (3) @(negedge clk);

        // R4 latency, then R5 single short request
        test_req_n = 1'b0;
        lat = 0;
        for (int i = 0; i < 10 && link_down_n; i++) begin @(negedge clk); lat++; end
        check(lat == 3, "R4", "edges to link down", lat, 3);
        words = 0; clrs = 0;
        for (int i = 0; i < 40; i++) begin
            if (i == 1) test_req_n = 1'b1;
            if (clr_pulse) clrs++;
            if (!test_active) break;
            if (data_valid) words++;
            @(negedge clk);
        end
        check(words == W + 1, "R5", "words for short request", words, W + 1);
        check(clrs == 2, "R8", "clear pulses", clrs, 2);
        repeat (6) @(negedge clk);
        check(!test_active && link_down_n, "R5", "stays idle after one sequence", test_active, 0);

        // R3 continuous repetition
        test_req_n = 1'b0;
        for (int i = 0; i < 10 && !test_active; i++) @(negedge clk);
        t = 0;
        for (int i = 0; i < 3 * (W + 1) + 2; i++) begin
            if (data_valid && !link_ctrl_n) zpos.push_back(t);
            t++;
            @(negedge clk);
        end
        check(zpos.size() >= 3, "R3", "zero words seen", zpos.size(), 3);
        if (zpos.size() >= 3) begin
            check(zpos[1] - zpos[0] == W + 1, "R3", "period 1", zpos[1] - zpos[0], W + 1);
            check(zpos[2] - zpos[1] == W + 1, "R3", "period 2", zpos[2] - zpos[1], W + 1);
        end

        // R6 pause with forwarding enabled
        fwd_en_n = 1'b0;
        repeat (3) @(negedge clk);
        held = link_data;
        pause_n = 1'b0;
        @(negedge clk);
        check(link_data == held && !data_valid, "R6", "held word 1", link_data, held);
        @(negedge clk);
        check(link_data == held && !data_valid, "R6", "held word 2", link_data, held);
        pause_n = 1'b1;
        @(negedge clk);
        check(link_data != held && data_valid, "R6", "resume advances", link_data, held);

        // R7 pause ignored with forwarding disabled
        fwd_en_n = 1'b1;
        pause_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            prev = link_data;
            @(negedge clk);
            check(link_data != prev && data_valid, "R7", "advance despite pause", link_data, prev);
        end
        pause_n = 1'b1;

        // R5 deferred exit at end of sequence
        test_req_n = 1'b1;
        last_w = '0;
        for (int i = 0; i < 40 && test_active; i++) begin
            last_w = link_data;
            @(negedge clk);
        end
        check(!test_active, "R5", "left test mode", test_active, 0);
        check(last_w == (W'(1) << (W - 1)), "R5", "last word before exit", last_w, 1 << (W - 1));
        repeat (4) @(negedge clk);
        check(link_data == '0 && link_ctrl_n && link_down_n, "R9", "idle after exit", link_data, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule